// File: doc/BRIEF.md
# Command Packet Header Dispatcher

This block selects the firmware handler for each command-stream packet. After the microcontroller executes its wait-for-input step, it presents the 32-bit packet header (the value held in general register 1) together with a one-cycle request. The dispatcher classifies the header as a register-write packet (type nibble 4) or an opcode packet (type nibble 7). It then returns three things one cycle later: the payload dword count, which is loaded into the remaining-count register; the new program counter, taken from a handler jump table; and the header value the handler should see. A header with any other type nibble raises a fault instead.

The jump table is filled by firmware during bootstrap through a write port whose address starts at zero and advances by one on every accepted write. Bootstrap is complete once that address reaches the table depth (128). After that, further writes are dropped. Register-write packets always use the last table slot. Opcode packets index the table by their opcode field.

Top module: `pkt_dispatch`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows disp_done=0, disp_fault=0, boot_done=0, disp_pc=0, disp_count=0, disp_hdr_out=0, and the table write address returns to 0.
- R2: Each cycle with tbl_wr_en=1 and boot_done=0 stores tbl_wr_data into the table entry at the current write address, then advances the write address by one. The first write after reset goes to entry 0.
- R3: boot_done rises in the cycle after the 128th accepted write and stays high until reset. Writes made while boot_done=1 change no table entry.
- R4: A request whose header has bits [31:28]=7 gives, one cycle later, disp_done=1, disp_pc = table[header bits 22:16], disp_count = header bits 14:0, and disp_hdr_out = the header unchanged.
- R5: A request whose header has bits [31:28]=4 gives, one cycle later, disp_done=1, disp_pc = table[127], disp_count = header bits 6:0 (zero-extended), and disp_hdr_out = header AND 0x0fffffff.
- R6: A request whose header has bits [31:28] equal to neither 4 nor 7 gives, one cycle later, disp_fault=1 and disp_done=0, and leaves disp_pc, disp_count and disp_hdr_out unchanged.
- R7: In a cycle after one without a request, disp_done and disp_fault are 0 and disp_pc, disp_count and disp_hdr_out keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_wr_en | input | 1 | Write one jump-table entry at the auto-incrementing address |
| tbl_wr_data | input | PC_W (12) | Handler address to store |
| boot_done | output | 1 | Table fully written; further writes ignored |
| disp_req | input | 1 | Dispatch request following a wait-for-input step |
| disp_hdr | input | 32 | Packet header (general register 1) |
| disp_done | output | 1 | One-cycle pulse: dispatch results valid |
| disp_fault | output | 1 | One-cycle pulse: header type invalid |
| disp_pc | output | PC_W (12) | Handler address loaded into the PC |
| disp_count | output | CNT_W (15) | Payload dword count for the remaining-count register |
| disp_hdr_out | output | 32 | Header value written back to register 1 |

## Verification
Suppose the table write pointer is wrong: skipped, stuck or wrapping. The error stays hidden until a dispatch reads an affected slot. It then shows as a wrong disp_pc one cycle after that request. For that reason the bench fills the table with distinct values and dispatches through both the fixed slot 127 and the low slots after an overflowing write. A misread type nibble or count field shows on the very next cycle as a swapped disp_done/disp_fault pulse, a wrong count or an unmasked header. Random headers spread over all sixteen type nibbles expose such errors quickly.

// File: rtl/pkt_dispatch_pkg.sv
// Shared constants and types for the packet header dispatcher.
package pkt_dispatch_pkg;
    localparam int HDR_W = 32;
    localparam logic [3:0] TYPE_REGWR = 4'h4;
    localparam logic [3:0] TYPE_OPC   = 4'h7;
    localparam logic [HDR_W-1:0] TYPE_STRIP_MASK = 32'h0fff_ffff;

    typedef enum logic [1:0] {
        PK_REGWR = 2'd0,
        PK_OPC   = 2'd1,
        PK_BAD   = 2'd2
    } pkt_kind_t;
endpackage

// File: rtl/hdr_decode.sv
// Combinational header classifier.
// Works out the packet kind from bits [31:28], the jump-table index, the
// payload count and the header value the handler will see.
// Assumes the opcode field starts at bit 16 and is IDX_W bits wide.
module hdr_decode
    import pkt_dispatch_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int CNT_W = 15,
    parameter int REGWR_CNT_W = 7
) (
    input  logic [HDR_W-1:0] hdr,
    output pkt_kind_t        kind,
    output logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] count,
    output logic [HDR_W-1:0] hdr_fwd
);
    localparam logic [IDX_W-1:0] REGWR_SLOT = {IDX_W{1'b1}};

    // Classify the header and pick the table index, the count and the forwarded header.
    always_comb begin
        kind    = PK_BAD;
        idx     = '0;
        count   = '0;
        hdr_fwd = hdr;
        if (hdr[31:28] == TYPE_REGWR) begin
            kind    = PK_REGWR;
            idx     = REGWR_SLOT;
            count   = CNT_W'(hdr[REGWR_CNT_W-1:0]);
            hdr_fwd = hdr & TYPE_STRIP_MASK;
        end else if (hdr[31:28] == TYPE_OPC) begin
            kind    = PK_OPC;
            idx     = hdr[16 +: IDX_W];
            count   = hdr[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/jump_table.sv
// Handler jump table with one write port and one combinational read port.
// Writes land at an internal address that starts at 0 after reset and
// advances on each accepted write. Once the address reaches DEPTH the
// table counts as loaded and later writes are dropped.
module jump_table #(
    parameter int DEPTH = 128,
    parameter int PC_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [PC_W-1:0]          wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [PC_W-1:0]          rd_data,
    output logic                     full
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int AW    = IDX_W + 1;

    logic [AW-1:0]   wr_ptr;
    logic [PC_W-1:0] entry [DEPTH];
    logic            wr_ok;

    assign full  = (wr_ptr == AW'(DEPTH));
    assign wr_ok = wr_en && !full;

    // Advance the write address on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)     wr_ptr <= '0;
        else if (wr_ok) wr_ptr <= wr_ptr + AW'(1);
    end

    // One storage register per entry, loaded when the write address selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)                               entry[g] <= '0;
            else if (wr_ok && wr_ptr == AW'(g))       entry[g] <= wr_data;
        end
    end

    assign rd_data = entry[rd_idx];
endmodule

// File: rtl/pkt_dispatch.sv
// Packet header dispatcher top level.
// On disp_req it classifies disp_hdr and registers the handler PC, the
// payload count and the forwarded header, or raises a fault pulse.
// Assumes disp_req is a single-cycle pulse per wait-for-input step.
module pkt_dispatch
    import pkt_dispatch_pkg::*;
#(
    parameter int PC_W      = 12,
    parameter int CNT_W     = 15,
    parameter int TBL_DEPTH = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_wr_en,
    input  logic [PC_W-1:0]   tbl_wr_data,
    output logic              boot_done,
    input  logic              disp_req,
    input  logic [HDR_W-1:0]  disp_hdr,
    output logic              disp_done,
    output logic              disp_fault,
    output logic [PC_W-1:0]   disp_pc,
    output logic [CNT_W-1:0]  disp_count,
    output logic [HDR_W-1:0]  disp_hdr_out
);
    localparam int IDX_W = $clog2(TBL_DEPTH);

    pkt_kind_t        kind;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] count_d;
    logic [HDR_W-1:0] hdr_fwd;
    logic [PC_W-1:0]  tbl_pc;
    logic             tbl_full;

    hdr_decode #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_dec (
        .hdr(disp_hdr), .kind(kind), .idx(idx), .count(count_d), .hdr_fwd(hdr_fwd)
    );

    jump_table #(.DEPTH(TBL_DEPTH), .PC_W(PC_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_data(tbl_wr_data),
        .rd_idx(idx), .rd_data(tbl_pc), .full(tbl_full)
    );

    // Register the bootstrap-complete flag.
    always_ff @(posedge clk) begin
        if (!rst_n) boot_done <= 1'b0;
        else        boot_done <= tbl_full;
    end

    // Produce the done and fault pulses for each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_done  <= 1'b0;
            disp_fault <= 1'b0;
        end else begin
            disp_done  <= disp_req && (kind != PK_BAD);
            disp_fault <= disp_req && (kind == PK_BAD);
        end
    end

    // Capture the dispatch results on every valid request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_pc      <= '0;
            disp_count   <= '0;
            disp_hdr_out <= '0;
        end else if (disp_req && kind != PK_BAD) begin
            disp_pc      <= tbl_pc;
            disp_count   <= count_d;
            disp_hdr_out <= hdr_fwd;
        end
    end
endmodule

// File: rtl/pkt_dispatch_chk.sv
// Checker for the packet header dispatcher, bound to every instance of the top.
module pkt_dispatch_chk #(
    parameter int PC_W  = 12,
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             boot_done,
    input logic             disp_req,
    input logic [31:0]      disp_hdr,
    input logic             disp_done,
    input logic             disp_fault,
    input logic [PC_W-1:0]  disp_pc,
    input logic [CNT_W-1:0] disp_count,
    input logic [31:0]      disp_hdr_out
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!disp_done && !disp_fault && !boot_done));

    // R3
    boot_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> boot_done);

    // R4
    done_has_valid_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_done |-> ($past(disp_req) &&
                       ($past(disp_hdr[31:28]) == 4'h4 || $past(disp_hdr[31:28]) == 4'h7)));

    // R5
    type_nibble_stripped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_req && disp_hdr[31:28] == 4'h4) |=> (disp_done && disp_hdr_out[31:28] == 4'h0));

    // R6
    bad_header_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_req && disp_hdr[31:28] != 4'h4 && disp_hdr[31:28] != 4'h7)
            |=> (disp_fault && !disp_done && $stable(disp_pc) && $stable(disp_count)));

    // R7
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_req |=> (!disp_done && !disp_fault && $stable(disp_pc) &&
                       $stable(disp_count) && $stable(disp_hdr_out)));
endmodule

bind pkt_dispatch pkt_dispatch_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .boot_done(boot_done), .disp_req(disp_req),
    .disp_hdr(disp_hdr), .disp_done(disp_done), .disp_fault(disp_fault),
    .disp_pc(disp_pc), .disp_count(disp_count), .disp_hdr_out(disp_hdr_out)
);

// File: tb/tb_pkt_dispatch.sv
module tb_pkt_dispatch;
    localparam int PC_W = 12;
    localparam int CNT_W = 15;
    localparam int DEPTH = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tbl_wr_en = 1'b0;
    logic [PC_W-1:0] tbl_wr_data = '0;
    logic boot_done;
    logic disp_req = 1'b0;
    logic [31:0] disp_hdr = '0;
    logic disp_done, disp_fault;
    logic [PC_W-1:0] disp_pc;
    logic [CNT_W-1:0] disp_count;
    logic [31:0] disp_hdr_out;

    int checks = 0;
    int fails = 0;
    logic [PC_W-1:0] model_tbl [DEPTH];
    logic [PC_W-1:0] last_pc = '0;
    logic [CNT_W-1:0] last_cnt = '0;
    logic [31:0] last_hdr = '0;

    always #5 clk = ~clk;

    pkt_dispatch dut (
        .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_data(tbl_wr_data),
        .boot_done(boot_done), .disp_req(disp_req), .disp_hdr(disp_hdr),
        .disp_done(disp_done), .disp_fault(disp_fault), .disp_pc(disp_pc),
        .disp_count(disp_count), .disp_hdr_out(disp_hdr_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [PC_W-1:0] fill_val(input int i);
        return PC_W'((i * 37 + 5) & 12'hfff);
    endfunction

    task automatic tbl_write(input logic [PC_W-1:0] d);
        @(negedge clk);
        tbl_wr_en = 1'b1;
        tbl_wr_data = d;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    // Issue one request and check the outputs one cycle later.
    task automatic dispatch(input logic [31:0] h);
        logic [3:0] t;
        t = h[31:28];
        @(negedge clk);
        disp_req = 1'b1;
        disp_hdr = h;
        @(negedge clk);
        disp_req = 1'b0;
        if (t == 4'h7) begin
            last_pc = model_tbl[h[22:16]];
            last_cnt = h[14:0];
            last_hdr = h;
            chk("R4 done", 32'(disp_done), 32'd1);
            chk("R4 pc", 32'(disp_pc), 32'(last_pc));
            chk("R4 count", 32'(disp_count), 32'(last_cnt));
            chk("R4 hdr", disp_hdr_out, last_hdr);
        end else if (t == 4'h4) begin
            last_pc = model_tbl[DEPTH-1];
            last_cnt = CNT_W'(h[6:0]);
            last_hdr = h & 32'h0fff_ffff;
            chk("R5 done", 32'(disp_done), 32'd1);
            chk("R5 pc", 32'(disp_pc), 32'(last_pc));
            chk("R5 count", 32'(disp_count), 32'(last_cnt));
            chk("R5 hdr", disp_hdr_out, last_hdr);
        end else begin
            chk("R6 fault", 32'(disp_fault), 32'd1);
            chk("R6 done", 32'(disp_done), 32'd0);
            chk("R6 pc held", 32'(disp_pc), 32'(last_pc));
            chk("R6 count held", 32'(disp_count), 32'(last_cnt));
            chk("R6 hdr held", disp_hdr_out, last_hdr);
        end
        @(negedge clk);
        chk("R7 done idle", 32'(disp_done), 32'd0);
        chk("R7 fault idle", 32'(disp_fault), 32'd0);
        chk("R7 pc held", 32'(disp_pc), 32'(last_pc));
    endtask

    initial begin
        int wd;
        wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 100000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=100000 cycles", wd);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h1234_5eed));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 done", 32'(disp_done), 32'd0);
        chk("R1 fault", 32'(disp_fault), 32'd0);
        chk("R1 boot", 32'(boot_done), 32'd0);
        chk("R1 pc", 32'(disp_pc), 32'd0);
        chk("R1 count", 32'(disp_count), 32'd0);
        chk("R1 hdr", disp_hdr_out, 32'd0);
        rst_n = 1'b1;

        // R2 fill all but the last entry, boot must still be pending
        for (int i = 0; i < DEPTH - 1; i++) begin
            model_tbl[i] = fill_val(i);
            tbl_write(model_tbl[i]);
        end
        model_tbl[DEPTH-1] = fill_val(DEPTH-1);
        @(negedge clk);
        chk("R3 boot low at 127", 32'(boot_done), 32'd0);
        tbl_write(model_tbl[DEPTH-1]);
        @(negedge clk);
        chk("R3 boot high at 128", 32'(boot_done), 32'd1);

        // R3 overflowing writes must change nothing
        tbl_write(12'hABC);
        tbl_write(12'h123);
        chk("R3 boot stays", 32'(boot_done), 32'd1);
        dispatch(32'h7000_0003);           // opcode 0: R2 first entry, R3 no wrap
        dispatch(32'h7001_0000);           // opcode 1: R2 second entry
        dispatch(32'h4ABC_DE7F);           // slot 127, max type-4 count (R5)
        dispatch(32'h707F_7FFF);           // opcode 127, max count (R4)
        dispatch(32'h0000_0000);           // R6 type 0
        dispatch(32'hF7FF_FFFF);           // R6 type 15

        // Random mix (R4 R5 R6 R7)
        for (int n = 0; n < 300; n++) begin
            logic [31:0] h;
            logic [3:0] t;
            int sel;
            h = $urandom;
            sel = int'($urandom % 4);
            if (sel == 0) t = 4'h4;
            else if (sel == 1 || sel == 3) t = 4'h7;
            else begin
                t = 4'($urandom % 16);
                if (t == 4'h4 || t == 4'h7) t = t + 4'h1;
            end
            h[31:28] = t;
            dispatch(h);
        end

        // R1 reset mid-run clears outputs and the write address
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 boot cleared", 32'(boot_done), 32'd0);
        chk("R1 pc cleared", 32'(disp_pc), 32'd0);
        rst_n = 1'b1;
        tbl_write(12'h5A5);
        model_tbl[0] = 12'h5A5;
        dispatch(32'h7000_0001);           // R2 write address restarted at 0

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule